// File: doc/BRIEF.md
# I2C Master Bus Sequencer

This block is the bus-facing engine of an I2C master. Software, or a controller above it, issues single-cycle command strobes: start, repeated start, stop, receive one byte, and send an acknowledge bit. A byte write into the data buffer launches a nine-clock transmit: eight data bits, most significant first, followed by one clock in which the slave answers. SCL and SDA are open-drain lines, so the block only reports when it pulls each line low. Its input is the level that SDA actually has on the bus.

A reloadable baud counter sets the timing. Each half of an SCL period lasts `reload + 1` clock cycles, so a full period lasts two rollovers of the counter. At the end of every sequence the block raises a sticky completion flag. A write into the buffer while the engine is working is refused, and it sets a sticky collision flag. A receive request that arrives while any sequence is still running is dropped. Addressing, whether 7-bit or 10-bit, is composed by the caller from start, repeated start and byte writes. A repeated start followed by a 10-bit high address byte with a write direction runs like any other byte.

Top module: `i2c_master_core`

## Requirements
- R1: Each SCL half (low or high) inside a byte lasts `reload + 1` clock cycles, so one SCL period is two baud rollovers. A reload of 0 is legal and gives a two-cycle period.
- R2: A start pulls SDA low while SCL is high and then pulls SCL low. A repeated start first releases SDA with SCL low, raises SCL, then pulls SDA low. A stop raises SCL with SDA low, then releases SDA and leaves both lines released. Outside these three conditions SDA never changes while SCL stays high.
- R3: A buffer write taken while the engine is not busy shifts the byte out MSB first over 8 SCL clocks. SDA is then released for a 9th clock, and the SDA level sampled at the end of its high half is stored in `ack_stat` (0 = acknowledged).
- R4: A receive samples SDA at the end of each of 8 SCL high halves, with SDA released, and assembles the bits MSB first. At completion `rx_data` holds the byte and `buf_full` is 1. A `rd_en` pulse clears `buf_full`.
- R5: The acknowledge command drives `ack_val` onto SDA for exactly one SCL clock: 0 pulls SDA low (ACK) and 1 leaves it released (NACK).
- R6: `cmd_rcv` is acted on only when no start, repeated start, stop, receive, acknowledge or byte transmit is in progress. Otherwise it has no effect.
- R7: `wr_en` while the engine is busy (or in the same cycle as a command strobe) sets `wcol`, which stays 1 until `clr_wcol`. The byte being shifted is unchanged.
- R8: The end of every start, repeated start, stop, byte transmit, byte receive or acknowledge sets `irq`. It stays 1 until `clr_irq`.
- R9: `cmd_active` shows the running command as one bit: bit 0 start, bit 1 repeated start, bit 2 stop, bit 3 receive, bit 4 acknowledge. The bit clears by itself when the sequence ends.
- R10: After a repeated start, a write of a 10-bit high address byte with R/W = 0 (`8'b11110xx0`) completes with the slave's ACK in `ack_stat`. The following low-address byte write is then accepted without collision.
- R11: After reset both lines are released and `irq`, `wcol`, `buf_full` and `cmd_active` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start-condition strobe |
| cmd_rstart | input | 1 | Repeated-start strobe |
| cmd_stop | input | 1 | Stop-condition strobe |
| cmd_rcv | input | 1 | Receive-one-byte strobe |
| cmd_ack | input | 1 | Acknowledge-sequence strobe |
| ack_val | input | 1 | Bit sent by the acknowledge sequence (0 ACK, 1 NACK) |
| wr_en | input | 1 | Buffer write strobe; starts a transmit |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Buffer read strobe; clears `buf_full` |
| clr_irq | input | 1 | Clears `irq` |
| clr_wcol | input | 1 | Clears `wcol` |
| reload | input | RELOAD_W | Baud counter reload value |
| sda_in | input | 1 | Sensed SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last received byte |
| buf_full | output | 1 | Received byte waiting |
| irq | output | 1 | Sticky completion flag |
| wcol | output | 1 | Sticky write-collision flag |
| ack_stat | output | 1 | Acknowledge level seen after the last transmit |
| cmd_active | output | 5 | Running command, one bit per command |
| busy | output | 1 | A sequence is running |

## Verification
The hardest case to reach is a receive strobe or a buffer write that lands in the middle of a byte. Reaching it needs a request that is otherwise legal, timed against a transfer that is already running. The stimulus starts a transmit, waits a fixed number of cycles into the bit stream, and then pulses `cmd_rcv` and `wr_en` with a different byte. After that it checks three things: the bus shows only the original nine bits, `wcol` is set, and no receive clocks follow. A bus-level slave model in the bench acknowledges or supplies data. It also decodes start, stop and every nine-bit group, so the 10-bit repeated-start path and the reload-of-zero case are compared at the pins.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int NCMD   = 5;

    // command vector positions
    localparam int C_START  = 0;
    localparam int C_RSTART = 1;
    localparam int C_STOP   = 2;
    localparam int C_RCV    = 3;
    localparam int C_ACK    = 4;

    typedef enum logic [4:0] {
        PH_IDLE, PH_HOLD,
        PH_S1, PH_S2, PH_S3,
        PH_R1, PH_R2, PH_R3, PH_R4,
        PH_P1, PH_P2, PH_P3,
        PH_TL, PH_TH, PH_AL, PH_AH,
        PH_RL, PH_RH,
        PH_KL, PH_KH
    } phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } lines_t;

    // line drive for every phase: 1 means pull low
    function automatic lines_t lines_of(phase_e ph, logic tx_bit, logic ack_low);
        lines_t l;
        unique case (ph)
            PH_IDLE, PH_S1, PH_R2, PH_P3, PH_AH, PH_RH: l = '{1'b0, 1'b0};
            PH_HOLD, PH_R1, PH_AL, PH_RL:               l = '{1'b1, 1'b0};
            PH_S2, PH_R3, PH_P2:                        l = '{1'b0, 1'b1};
            PH_S3, PH_R4, PH_P1:                        l = '{1'b1, 1'b1};
            PH_TL:                                      l = '{1'b1, ~tx_bit};
            PH_TH:                                      l = '{1'b0, ~tx_bit};
            PH_KL:                                      l = '{1'b1, ack_low};
            PH_KH:                                      l = '{1'b0, ack_low};
            default:                                    l = '{1'b0, 1'b0};
        endcase
        return l;
    endfunction

    function automatic logic [NCMD-1:0] owner_of(phase_e ph);
        logic [NCMD-1:0] v;
        v = '0;
        unique case (ph)
            PH_S1, PH_S2, PH_S3:        v[C_START]  = 1'b1;
            PH_R1, PH_R2, PH_R3, PH_R4: v[C_RSTART] = 1'b1;
            PH_P1, PH_P2, PH_P3:        v[C_STOP]   = 1'b1;
            PH_RL, PH_RH:               v[C_RCV]    = 1'b1;
            PH_KL, PH_KH:               v[C_ACK]    = 1'b1;
            default:                    v = '0;
        endcase
        return v;
    endfunction

    // phases after which SDA may move while SCL is high
    function automatic logic sda_edge_ok(phase_e ph);
        return (ph == PH_S1) || (ph == PH_R2) || (ph == PH_P2);
    endfunction

endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    logic [RELOAD_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (!run || tick)  cnt <= reload;
        else                    cnt <= cnt - 1'b1;
    end

    AST_BAUD_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && reload != '0) |=> !tick);  // R1

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NCMD-1:0]   cmd,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ack_val,
    input  logic              sda_in,
    output logic              busy,
    output lines_t            lines,
    output logic [NCMD-1:0]   active,
    output logic              ack_stat,
    output logic              done,
    output logic              rx_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    phase_e            ph;
    logic [BIT_CW-1:0] bitn;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              ack_low;

    assign busy   = !(ph == PH_IDLE || ph == PH_HOLD);
    assign lines  = lines_of(ph, tx_sh[BYTE_W-1], ack_low);
    assign active = owner_of(ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            bitn     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            ack_low  <= 1'b0;
            ack_stat <= 1'b0;
            done     <= 1'b0;
            rx_done  <= 1'b0;
            rx_byte  <= '0;
        end else begin
            done    <= 1'b0;
            rx_done <= 1'b0;
            if (!busy) begin
                if (cmd[C_START])       ph <= PH_S1;
                else if (cmd[C_RSTART]) ph <= PH_R1;
                else if (cmd[C_STOP])   ph <= PH_P1;
                else if (cmd[C_RCV]) begin
                    ph   <= PH_RL;
                    bitn <= '0;
                end else if (cmd[C_ACK]) begin
                    ph      <= PH_KL;
                    ack_low <= ~ack_val;
                end else if (wr_en) begin
                    ph    <= PH_TL;
                    bitn  <= '0;
                    tx_sh <= wr_data;
                end
            end else if (tick) begin
                unique case (ph)
                    PH_S1: ph <= PH_S2;
                    PH_S2: ph <= PH_S3;
                    PH_R1: ph <= PH_R2;
                    PH_R2: ph <= PH_R3;
                    PH_R3: ph <= PH_R4;
                    PH_P1: ph <= PH_P2;
                    PH_P2: ph <= PH_P3;
                    PH_TL: ph <= PH_TH;
                    PH_AL: ph <= PH_AH;
                    PH_RL: ph <= PH_RH;
                    PH_KL: ph <= PH_KH;
                    PH_S3, PH_R4, PH_KH: begin
                        ph   <= PH_HOLD;
                        done <= 1'b1;
                    end
                    PH_P3: begin
                        ph   <= PH_IDLE;
                        done <= 1'b1;
                    end
                    PH_TH: begin
                        if (bitn == LAST_BIT) ph <= PH_AL;
                        else begin
                            ph    <= PH_TL;
                            bitn  <= bitn + 1'b1;
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                    PH_AH: begin
                        ack_stat <= sda_in;
                        ph       <= PH_HOLD;
                        done     <= 1'b1;
                    end
                    PH_RH: begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
                        if (bitn == LAST_BIT) begin
                            rx_byte <= {rx_sh[BYTE_W-2:0], sda_in};
                            rx_done <= 1'b1;
                            done    <= 1'b1;
                            ph      <= PH_HOLD;
                        end else begin
                            bitn <= bitn + 1'b1;
                            ph   <= PH_RL;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!lines.scl_low && !$past(lines.scl_low) && (lines.sda_low != $past(lines.sda_low)))
        |-> sda_edge_ok($past(ph)));  // R2

    AST_TX_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !tick) |=> $stable(tx_sh));  // R7

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done |-> (active == '0) && !busy);  // R9

endmodule

// File: rtl/i2c_master_core.sv
module i2c_master_core
    import i2cm_pkg::*;
#(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_start,
    input  logic                cmd_rstart,
    input  logic                cmd_stop,
    input  logic                cmd_rcv,
    input  logic                cmd_ack,
    input  logic                ack_val,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    input  logic                clr_irq,
    input  logic                clr_wcol,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                sda_in,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic [7:0]          rx_data,
    output logic                buf_full,
    output logic                irq,
    output logic                wcol,
    output logic                ack_stat,
    output logic [4:0]          cmd_active,
    output logic                busy
);
    logic [NCMD-1:0] cmd;
    logic            tick;
    logic            done;
    logic            rx_done;
    lines_t          lines;

    assign cmd = {cmd_ack, cmd_rcv, cmd_stop, cmd_rstart, cmd_start};

    i2cm_baud #(.RELOAD_W(RELOAD_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .reload (reload),
        .tick   (tick)
    );

    i2cm_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd      (cmd),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ack_val  (ack_val),
        .sda_in   (sda_in),
        .busy     (busy),
        .lines    (lines),
        .active   (cmd_active),
        .ack_stat (ack_stat),
        .done     (done),
        .rx_done  (rx_done),
        .rx_byte  (rx_data)
    );

    assign scl_oe = lines.scl_low;
    assign sda_oe = lines.sda_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            wcol     <= 1'b0;
            buf_full <= 1'b0;
        end else begin
            if (done)         irq <= 1'b1;
            else if (clr_irq) irq <= 1'b0;

            if (wr_en && (busy || (|cmd))) wcol <= 1'b1;
            else if (clr_wcol)             wcol <= 1'b0;

            if (rx_done)    buf_full <= 1'b1;
            else if (rd_en) buf_full <= 1'b0;
        end
    end

    AST_RCV_GATED: assert property (@(posedge clk) disable iff (rst)
        (cmd_rcv && busy && !cmd_active[C_RCV]) |=> !cmd_active[C_RCV]);  // R6

    AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> wcol);  // R7

    AST_WCOL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wcol && !clr_wcol) |=> wcol);  // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_irq) |=> irq);  // R8

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_active) && (!(|cmd_active) || busy));  // R9

endmodule

// File: tb/sim_i2c_master_core.sv
module sim_i2c_master_core;
    localparam int RW      = 8;
    localparam int EV_START = 1024;
    localparam int EV_STOP  = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rcv = 0, cmd_ack = 0;
    logic          ack_val = 0, wr_en = 0, rd_en = 0, clr_irq = 0, clr_wcol = 0;
    logic [7:0]    wr_data = '0;
    logic [RW-1:0] rl = 8'd3;
    logic          scl_oe, sda_oe, buf_full, irq, wcol, ack_stat, busy;
    logic [7:0]    rx_data;
    logic [4:0]    cmd_active;

    // bus and slave model
    int         slv_mode = 0;  // 0 silent, 1 tx+ack, 2 tx+nack, 3 send byte
    logic [7:0] slv_byte = '0;
    int         slv_idx  = 0;
    logic       slv_low;
    logic       scl_line, sda_line;

    always_comb begin
        slv_low = 1'b0;
        if (slv_mode == 1 && slv_idx == 8) slv_low = 1'b1;
        if (slv_mode == 3 && slv_idx < 8)  slv_low = !slv_byte[7 - slv_idx];
    end
    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe | slv_low);

    i2c_master_core #(.RELOAD_W(RW)) u0 (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_val(ack_val),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .clr_irq(clr_irq), .clr_wcol(clr_wcol), .reload(rl), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .buf_full(buf_full),
        .irq(irq), .wcol(wcol), .ack_stat(ack_stat), .cmd_active(cmd_active), .busy(busy)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    exp_q[$];
    string req_q[$];
    bit    finished = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(int v, string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    task automatic take(int v);
        int    e;
        string r;
        if (exp_q.size() == 0) begin
            chk(0, "R2", v, 0);
        end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(v == e, r, v, e);
        end
    endtask

    // monitor: decodes conditions and 9-bit groups, times SCL halves
    logic       scl_p = 1, sda_p = 1, pend = 0;
    bit         pend_v = 0, half_bad = 0;
    int         nb = 0, cyc = 0, t_rise = 0, t_fall = 0;
    logic [8:0] sh = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (scl_p && scl_line && sda_p && !sda_line) begin
                take(EV_START);
                nb = 0; slv_idx = 0; pend_v = 0; half_bad = 0;
            end else if (scl_p && scl_line && !sda_p && sda_line) begin
                take(EV_STOP);
                nb = 0; slv_idx = 0; pend_v = 0;
            end else if (!scl_p && scl_line) begin
                if (nb > 0 && nb < 8 && (cyc - t_fall) != int'(rl) + 1) half_bad = 1;
                t_rise = cyc;
                pend = sda_line;
                pend_v = 1;
            end else if (scl_p && !scl_line) begin
                t_fall = cyc;
                if (pend_v) begin
                    if ((cyc - t_rise) != int'(rl) + 1) half_bad = 1;
                    sh = {sh[7:0], pend};
                    pend_v = 0;
                    nb++;
                    slv_idx++;
                    if (nb == 9) begin
                        take(int'(sh));
                        chk(!half_bad, "R1", int'(half_bad), 0);
                        nb = 0; slv_idx = 0; half_bad = 0;
                    end
                end
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // driver tasks
    task automatic wait_irq();
        while (!irq) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R8", int'(irq), 1);
        clr_irq = 1; @(negedge clk); clr_irq = 0;
        chk(irq == 1'b0, "R8", int'(irq), 0);
    endtask

    task automatic do_start();
        slv_mode = 0;
        push(EV_START, "R2");
        cmd_start = 1; @(negedge clk); cmd_start = 0;
        chk(cmd_active == 5'b00001, "R9", int'(cmd_active), 1);
        wait_irq();
        chk(cmd_active == 5'b0, "R9", int'(cmd_active), 0);
    endtask

    task automatic do_rstart();
        slv_mode = 0;
        push(EV_START, "R2");
        cmd_rstart = 1; @(negedge clk); cmd_rstart = 0;
        chk(cmd_active == 5'b00010, "R9", int'(cmd_active), 2);
        wait_irq();
    endtask

    task automatic do_stop();
        slv_mode = 0;
        push(EV_STOP, "R2");
        cmd_stop = 1; @(negedge clk); cmd_stop = 0;
        chk(cmd_active == 5'b00100, "R9", int'(cmd_active), 4);
        wait_irq();
        chk(!scl_oe && !sda_oe && !busy, "R2", int'({scl_oe, sda_oe, busy}), 0);
    endtask

    task automatic do_write(logic [7:0] b, bit ack, string req);
        slv_mode = ack ? 1 : 2;
        push(int'({b, !ack}), req);
        wr_data = b; wr_en = 1; @(negedge clk); wr_en = 0;
        wait_irq();
        chk(ack_stat == !ack, req, int'(ack_stat), int'(!ack));
        slv_mode = 0;
    endtask

    task automatic do_read(logic [7:0] b, bit av);
        slv_byte = b; slv_mode = 3;
        push(int'({b, av}), "R5");
        cmd_rcv = 1; @(negedge clk); cmd_rcv = 0;
        chk(cmd_active == 5'b01000, "R9", int'(cmd_active), 8);
        wait_irq();
        chk(rx_data == b, "R4", int'(rx_data), int'(b));
        chk(buf_full == 1'b1, "R4", int'(buf_full), 1);
        rd_en = 1; @(negedge clk); rd_en = 0;
        chk(buf_full == 1'b0, "R4", int'(buf_full), 0);
        ack_val = av; cmd_ack = 1; @(negedge clk); cmd_ack = 0;
        chk(cmd_active == 5'b10000, "R9", int'(cmd_active), 16);
        wait_irq();
        slv_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(!scl_oe && !sda_oe, "R11", int'({scl_oe, sda_oe}), 0);
        chk(!irq && !wcol && !buf_full && cmd_active == 0, "R11",
            int'({irq, wcol, buf_full}), 0);

        // R3 plain transmits, ack and nack
        rl = 8'd3;
        do_start();
        do_write(8'hA5, 1, "R3");
        do_write(8'h3C, 0, "R3");
        do_stop();

        // R6 / R7 strobes in the middle of a byte
        do_start();
        slv_mode = 1;
        push(int'({8'h96, 1'b0}), "R7");
        wr_data = 8'h96; wr_en = 1; @(negedge clk); wr_en = 0;
        repeat (20) @(negedge clk);
        cmd_rcv = 1; wr_data = 8'hFF; wr_en = 1; @(negedge clk);
        cmd_rcv = 0; wr_en = 0;
        chk(wcol == 1'b1, "R7", int'(wcol), 1);
        chk(cmd_active == 5'b0, "R6", int'(cmd_active), 0);
        wait_irq();
        slv_mode = 0;
        chk(ack_stat == 1'b0, "R3", int'(ack_stat), 0);
        repeat (20) @(negedge clk);
        chk(!busy && cmd_active == 0 && scl_oe, "R6", int'({busy, scl_oe}), 1);
        chk(wcol == 1'b1, "R7", int'(wcol), 1);
        clr_wcol = 1; @(negedge clk); clr_wcol = 0;
        chk(wcol == 1'b0, "R7", int'(wcol), 0);

        // R4 / R5 receive with ACK then NACK
        do_write(8'h91, 1, "R3");
        do_read(8'h5A, 1'b0);
        do_read(8'hC3, 1'b1);
        do_stop();

        // R10 ten-bit address with repeated start
        do_start();
        do_write(8'hF0, 1, "R10");
        do_write(8'h34, 1, "R10");
        do_rstart();
        do_write(8'hF0, 1, "R10");
        chk(wcol == 1'b0, "R10", int'(wcol), 0);
        do_write(8'h34, 1, "R10");
        chk(wcol == 1'b0, "R10", int'(wcol), 0);
        do_write(8'h6E, 1, "R10");
        do_stop();

        // R1 fastest rate, reload 0
        rl = 8'd0;
        do_start();
        do_write(8'h81, 1, "R1");
        do_read(8'h7E, 1'b1);
        do_stop();

        repeat (50) @(negedge clk);
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000 && !finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8: watchdog, irq never came (got 0 expected 1)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule